// File: doc/BRIEF.md
# Partitioned Performance Counter Bank

This block holds six free-running event counters and splits them between a guest partition and a hypervisor partition. A programmable boundary value sets the split. Counters whose index is below the boundary belong to the guest. Counters at or above it belong to the hypervisor. Each partition has its own count enable. Event sources arrive as single-cycle pulses, one per counter.

Software reaches the bank through a single register port. Every request carries the requester's exception level (0 to 3) and a non-secure flag. The block checks each request against the partition rules, the user-access bit and the control-register trap bit. It then either completes the request or returns a one-cycle trap indication, which asks the core to take the exception at the hypervisor level. The response is registered and arrives one cycle after the request. An accepted write takes effect at the same clock edge that samples it.

Register map, with the 4-bit address: counters 0 to 5 at addresses 0 to 5; control at 8; user-access at 9; hypervisor configuration at 10. Any other address reads zero, ignores writes and never traps.

Top module: `perf_partition_bank`

## Requirements
- R1: After reset the boundary field reads 6, the trap bit is 0, both partition enables and the user-access bit are 0, and every counter reads 0. The control register reports the implemented counter count (6) in bits [15:11].
- R2: A counter increments by one on each cycle where its event pulse is high and its partition's enable is set. It wraps from 0xFFFFFFFF to 0 and otherwise holds its value.
- R3: A counter whose index is below the effective boundary counts only while the global enable (control bit 0) is set. A counter at or above the effective boundary counts only while the hypervisor enable (configuration bit 7) is set.
- R4: A non-secure EL1 access to a counter whose index is below the effective boundary completes. A non-secure EL1 access to any other counter traps.
- R5: Any EL0 access to a counter or to the control register traps unless the user-access bit (bit 0 at address 9) is set. When that bit is set, a non-secure EL0 access obeys the same partition rule as EL1. EL0 accesses to address 9 always trap.
- R6: Accesses from EL2, from EL3, and from secure state at EL1 reach every counter.
- R7: With a boundary of 0, every non-secure EL0 or EL1 counter access traps.
- R8: A stored boundary greater than 6 behaves as 6 for access checks and enable selection.
- R9: A read of the configuration register from EL2 or EL3 returns the boundary exactly as written (bits [4:0], including 0 and values above 6), along with the trap bit (bit 5) and the hypervisor enable (bit 7). EL0 and EL1 accesses to it trap.
- R10: While configuration bit 5 is set, non-secure EL0 and EL1 accesses to the control register trap. EL2 accesses still complete.
- R11: A trapped request raises rsp_trap for exactly the response cycle, returns read data 0 and leaves all registers unchanged.
- R12: When an accepted write to a counter coincides with a counted event, the written value wins. A read returns the counter value from before the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 32 | Write data |
| req_el | input | 2 | Requester exception level, 0 to 3 |
| req_ns | input | 1 | Requester is in non-secure state |
| evt_pulse | input | 6 | One event pulse per counter |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_trap | output | 1 | Previous request was refused and must trap to EL2 |
| rsp_rdata | output | 32 | Read data, 0 for writes and traps |

## Verification
The bound checker watches, on every cycle, the relations that need no history beyond one edge. These are: a trap is always paired with a response and follows a refused request; a refused request leaves the boundary unchanged; EL2 counter accesses never trap and configuration accesses from EL0/EL1 always do; a boundary of 0 refuses low-level non-secure counter accesses and hands every counter to the hypervisor enable; and counter 0 steps or holds exactly as its pulse and enable dictate. Some behaviours can only be shown by the bench's scenarios, because they depend on a sequence of writes followed by reads. These are: verbatim read-back of out-of-range boundaries, saturation above 6, the user-access and control-trap interplay, wrap-around, and write-over-increment precedence. The bench checks them against its own model of the register state.

// File: rtl/perf_part_pkg.sv
package perf_part_pkg;
  localparam int unsigned BND_W  = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd8;
  localparam logic [ADDR_W-1:0] A_USER = 4'd9;
  localparam logic [ADDR_W-1:0] A_HCFG = 4'd10;

  localparam int unsigned HCFG_TRAP_BIT = 5;
  localparam int unsigned HCFG_HEN_BIT  = 7;
  localparam int unsigned CTRL_NUM_LSB  = 11;

  // Effective boundary: stored value clipped to the implemented count.
  function automatic logic [BND_W-1:0] sat_bound(input logic [BND_W-1:0] raw,
                                                 input int unsigned lim);
    if (32'(raw) > lim) return BND_W'(lim);
    return raw;
  endfunction

  // Counter idx belongs to the guest partition.
  function automatic logic in_guest(input int unsigned idx,
                                    input logic [BND_W-1:0] eff);
    return idx < 32'(eff);
  endfunction
endpackage

// File: rtl/perf_access_check.sv
module perf_access_check
  import perf_part_pkg::*;
#(
  parameter int unsigned NUM_CNT = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        el,
  input  logic              ns,
  input  logic              user_en,
  input  logic              ctl_trap,
  input  logic [BND_W-1:0]  eff_bnd,
  output logic              trap,
  output logic              is_cnt
);
  logic low_ns;

  always_comb begin
    is_cnt = 32'(addr) < NUM_CNT;
    low_ns = ns && (el < 2'd2);
    trap   = 1'b0;
    if (is_cnt) begin
      if (el == 2'd0 && !user_en)                       trap = 1'b1;
      else if (low_ns && !in_guest(32'(addr), eff_bnd)) trap = 1'b1;
    end else if (addr == A_CTRL) begin
      if (el == 2'd0 && !user_en) trap = 1'b1;
      else if (low_ns && ctl_trap) trap = 1'b1;
    end else if (addr == A_USER) begin
      trap = (el == 2'd0);
    end else if (addr == A_HCFG) begin
      trap = (el < 2'd2);
    end
  end
endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (wr)  q <= wdata;
    else if (inc) q <= q + W'(1);
  end
endmodule

// File: rtl/perf_partition_bank.sv
module perf_partition_bank
  import perf_part_pkg::*;
#(
  parameter int unsigned NUM_CNT = 6,
  parameter int unsigned CNT_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [1:0]           req_el,
  input  logic                 req_ns,
  input  logic [NUM_CNT-1:0]   evt_pulse,
  output logic                 rsp_valid,
  output logic                 rsp_trap,
  output logic [DATA_W-1:0]    rsp_rdata
);
  logic [BND_W-1:0] bnd_q;
  logic             ctl_trap_q, hyp_en_q, glob_en_q, user_en_q;
  logic [BND_W-1:0] eff_bnd;
  logic             acc_trap, acc_is_cnt, wr_ok;
  logic [NUM_CNT-1:0] wr_hit, cnt_en;
  logic [CNT_W-1:0] cnt_q [NUM_CNT];
  logic [CNT_W-1:0] cnt0;
  logic [DATA_W-1:0] rd_mux;

  assign eff_bnd = sat_bound(bnd_q, NUM_CNT);
  assign wr_ok   = req_valid && req_write && !acc_trap;
  assign cnt0    = cnt_q[0];

  perf_access_check #(.NUM_CNT(NUM_CNT)) u_acc (
    .addr    (req_addr),
    .el      (req_el),
    .ns      (req_ns),
    .user_en (user_en_q),
    .ctl_trap(ctl_trap_q),
    .eff_bnd (eff_bnd),
    .trap    (acc_trap),
    .is_cnt  (acc_is_cnt)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign wr_hit[i] = wr_ok && (32'(req_addr) == i);
    assign cnt_en[i] = in_guest(i, eff_bnd) ? glob_en_q : hyp_en_q;
    perf_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (evt_pulse[i] && cnt_en[i]),
      .wr   (wr_hit[i]),
      .wdata(req_wdata[CNT_W-1:0]),
      .q    (cnt_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_q      <= BND_W'(NUM_CNT);
      ctl_trap_q <= 1'b0;
      hyp_en_q   <= 1'b0;
      glob_en_q  <= 1'b0;
      user_en_q  <= 1'b0;
    end else if (wr_ok) begin
      if (req_addr == A_CTRL) glob_en_q <= req_wdata[0];
      if (req_addr == A_USER) user_en_q <= req_wdata[0];
      if (req_addr == A_HCFG) begin
        bnd_q      <= req_wdata[BND_W-1:0];
        ctl_trap_q <= req_wdata[HCFG_TRAP_BIT];
        hyp_en_q   <= req_wdata[HCFG_HEN_BIT];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (acc_is_cnt) begin
      for (int i = 0; i < NUM_CNT; i++)
        if (32'(req_addr) == i) rd_mux = DATA_W'(cnt_q[i]);
    end else if (req_addr == A_CTRL) begin
      rd_mux[0] = glob_en_q;
      rd_mux[CTRL_NUM_LSB +: BND_W] = BND_W'(NUM_CNT);
    end else if (req_addr == A_USER) begin
      rd_mux[0] = user_en_q;
    end else if (req_addr == A_HCFG) begin
      rd_mux[BND_W-1:0]    = bnd_q;
      rd_mux[HCFG_TRAP_BIT] = ctl_trap_q;
      rd_mux[HCFG_HEN_BIT]  = hyp_en_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_trap  <= req_valid && acc_trap;
      rsp_rdata <= (req_valid && !acc_trap && !req_write) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/perf_partition_checker.sv
module perf_partition_checker
  import perf_part_pkg::*;
#(
  parameter int unsigned NUM_CNT = 6,
  parameter int unsigned CNT_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [1:0]         req_el,
  input logic               req_ns,
  input logic [NUM_CNT-1:0] evt_pulse,
  input logic               rsp_valid,
  input logic               rsp_trap,
  input logic               acc_trap,
  input logic [BND_W-1:0]   bnd_q,
  input logic               hyp_en_q,
  input logic [NUM_CNT-1:0] cnt_en,
  input logic [NUM_CNT-1:0] wr_hit,
  input logic [CNT_W-1:0]   cnt0
);
  p_trap_has_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> rsp_valid);

  p_trap_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_trap) |=> rsp_trap);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_trap);

  p_trap_keeps_bnd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_trap) |=> $stable(bnd_q));

  p_el2_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_el == 2'd2 && 32'(req_addr) < NUM_CNT) |=> !rsp_trap);

  p_hcfg_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr == A_HCFG && req_el < 2'd2) |=> rsp_trap);

  p_bnd0_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ns && req_el == 2'd1 && 32'(req_addr) < NUM_CNT
     && bnd_q == '0) |=> rsp_trap);

  p_bnd0_hyp_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_q == '0) |-> (cnt_en == {NUM_CNT{hyp_en_q}}));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse[0] && cnt_en[0] && !wr_hit[0]) |=> (cnt0 == $past(cnt0) + CNT_W'(1)));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_pulse[0] && !wr_hit[0]) |=> $stable(cnt0));
endmodule

bind perf_partition_bank perf_partition_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_addr (req_addr),
  .req_el   (req_el),
  .req_ns   (req_ns),
  .evt_pulse(evt_pulse),
  .rsp_valid(rsp_valid),
  .rsp_trap (rsp_trap),
  .acc_trap (acc_trap),
  .bnd_q    (bnd_q),
  .hyp_en_q (hyp_en_q),
  .cnt_en   (cnt_en),
  .wr_hit   (wr_hit),
  .cnt0     (cnt0)
);

// File: tb/perf_partition_bank_bench.sv
module perf_partition_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_ns = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_el = '0;
  logic [5:0]  evt_pulse = '0;
  logic        rsp_valid, rsp_trap;
  logic [31:0] rsp_rdata;

  always #2 clk = ~clk;

  perf_partition_bank u_perf_partition_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_el(req_el), .req_ns(req_ns),
    .evt_pulse(evt_pulse), .rsp_valid(rsp_valid), .rsp_trap(rsp_trap),
    .rsp_rdata(rsp_rdata)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_cnt [6];
  logic [4:0]  m_bnd;
  logic        m_trapbit, m_hen, m_gen, m_user;
  logic        last_trap;
  logic [31:0] last_data;

  function automatic int eff();
    return (m_bnd > 5'd6) ? 6 : int'(m_bnd);
  endfunction

  function automatic logic exp_trap(logic [3:0] a, logic [1:0] el, logic ns);
    logic low = ns && el != 2'd2 && el != 2'd3;
    if (a < 4'd6) return (el == 0 && !m_user) || (low && int'(a) >= eff());
    if (a == 4'd8) return (el == 0 && !m_user) || (low && m_trapbit);
    if (a == 4'd9) return el == 0;
    if (a == 4'd10) return el <= 1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_read(logic [3:0] a);
    if (a < 4'd6) return m_cnt[a];
    if (a == 4'd8) return {16'd0, 5'd6, 10'd0, m_gen};
    if (a == 4'd9) return {31'd0, m_user};
    if (a == 4'd10) return {24'd0, m_hen, 1'b0, m_trapbit, m_bnd};
    return 32'd0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(logic w, logic [3:0] a, logic [31:0] d, logic [1:0] el,
                    logic ns, logic [5:0] ev, string tag);
    logic et;
    logic [31:0] er;
    et = exp_trap(a, el, ns);
    er = (et || w) ? 32'd0 : exp_read(a);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    req_el = el; req_ns = ns; evt_pulse = ev;
    @(posedge clk);
    for (int i = 0; i < 6; i++) begin
      logic en = (i < eff()) ? m_gen : m_hen;
      if (!et && w && int'(a) == i) m_cnt[i] = d;
      else if (ev[i] && en) m_cnt[i] = m_cnt[i] + 32'd1;
    end
    if (!et && w) begin
      if (a == 4'd8) m_gen = d[0];
      if (a == 4'd9) m_user = d[0];
      if (a == 4'd10) begin m_bnd = d[4:0]; m_trapbit = d[5]; m_hen = d[7]; end
    end
    @(negedge clk);
    req_valid = 1'b0; evt_pulse = '0;
    last_trap = rsp_trap; last_data = rsp_rdata;
    check({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
    check({tag, " trap"}, {31'd0, rsp_trap}, {31'd0, et});
    check({tag, " rdata"}, rsp_rdata, er);
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7155));
    for (int i = 0; i < 6; i++) m_cnt[i] = '0;
    m_bnd = 5'd6; m_trapbit = 0; m_hen = 0; m_gen = 0; m_user = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 trap after reset", {31'd0, rsp_trap}, 32'd0);
    // R1 reset state
    op(0, 4'd10, 0, 2'd2, 1, 0, "R1 hcfg");
    check("R1 boundary 6", last_data, 32'h6);
    op(0, 4'd8, 0, 2'd3, 0, 0, "R1 ctrl");
    check("R1 count field", last_data, 32'h3000);
    for (int i = 0; i < 6; i++) op(0, 4'(i), 0, 2'd2, 1, 0, "R1 counter");
    // R4 partition access from NS EL1
    op(0, 4'd5, 0, 2'd1, 1, 0, "R4 full guest");
    op(1, 4'd10, 32'h3, 2'd2, 1, 0, "R4 set bnd");
    op(0, 4'd2, 0, 2'd1, 1, 0, "R4 below");
    op(0, 4'd3, 0, 2'd1, 1, 0, "R4 at boundary");
    check("R4 trap at boundary", {31'd0, last_trap}, 32'd1);
    // R6 privileged or secure bypass
    op(0, 4'd5, 0, 2'd2, 1, 0, "R6 el2");
    op(0, 4'd5, 0, 2'd1, 0, 0, "R6 secure el1");
    op(0, 4'd4, 0, 2'd3, 1, 0, "R6 el3");
    check("R6 no trap", {31'd0, last_trap}, 32'd0);
    // R5 user access gate
    op(0, 4'd0, 0, 2'd0, 1, 0, "R5 el0 closed");
    op(0, 4'd9, 0, 2'd0, 1, 0, "R5 el0 user reg");
    op(1, 4'd9, 32'h1, 2'd1, 1, 0, "R5 open");
    op(0, 4'd0, 0, 2'd0, 1, 0, "R5 el0 open");
    check("R5 el0 allowed", {31'd0, last_trap}, 32'd0);
    op(0, 4'd4, 0, 2'd0, 1, 0, "R5 el0 hyp part");
    // R7 boundary zero
    op(1, 4'd10, 32'h0, 2'd2, 1, 0, "R7 set 0");
    op(0, 4'd0, 0, 2'd1, 1, 0, "R7 el1 c0");
    check("R7 c0 trap", {31'd0, last_trap}, 32'd1);
    op(0, 4'd0, 0, 2'd0, 1, 0, "R7 el0 c0");
    // R8/R9 out of range boundary
    op(1, 4'd10, 32'h14, 2'd2, 1, 0, "R9 set 20");
    op(0, 4'd10, 0, 2'd2, 1, 0, "R9 readback");
    check("R9 verbatim 20", last_data, 32'h14);
    op(0, 4'd5, 0, 2'd1, 1, 0, "R8 c5 guest");
    check("R8 c5 open", {31'd0, last_trap}, 32'd0);
    op(0, 4'd10, 0, 2'd1, 1, 0, "R9 el1 hcfg");
    op(1, 4'd10, 32'h1F, 2'd3, 0, 0, "R9 set 31");
    op(0, 4'd10, 0, 2'd3, 0, 0, "R9 read 31");
    check("R9 verbatim 31", last_data, 32'h1F);
    // R3 enable selection with boundary 3
    op(1, 4'd10, 32'h3, 2'd2, 1, 0, "R3 bnd 3");
    op(1, 4'd8, 32'h1, 2'd2, 1, 0, "R3 glob on");
    for (int k = 0; k < 4; k++) op(0, 4'd15, 0, 2'd2, 1, 6'h3F, "R3 pulses");
    op(1, 4'd10, 32'h83, 2'd2, 1, 0, "R3 hyp on");
    op(1, 4'd8, 32'h0, 2'd2, 1, 0, "R3 glob off");
    for (int k = 0; k < 2; k++) op(0, 4'd15, 0, 2'd2, 1, 6'h3F, "R3 pulses");
    for (int i = 0; i < 6; i++) op(0, 4'(i), 0, 2'd2, 1, 0, "R3 counts");
    check("R3 c5 hyp count", last_data, 32'd2);
    // R11 trapped writes have no effect
    op(1, 4'd10, 32'h0, 2'd1, 1, 0, "R11 el1 hcfg wr");
    op(1, 4'd4, 32'h55, 2'd1, 1, 0, "R11 el1 c4 wr");
    idle();
    check("R11 one-cycle trap", {31'd0, rsp_trap}, 32'd0);
    op(0, 4'd10, 0, 2'd2, 1, 0, "R11 hcfg kept");
    op(0, 4'd4, 0, 2'd2, 1, 0, "R11 c4 kept");
    check("R11 c4 value", last_data, 32'd2);
    // R10 control trap bit
    op(1, 4'd10, 32'h26, 2'd2, 1, 0, "R10 set trap");
    op(0, 4'd8, 0, 2'd1, 1, 0, "R10 el1 ctrl");
    check("R10 ctrl trap", {31'd0, last_trap}, 32'd1);
    op(0, 4'd8, 0, 2'd0, 1, 0, "R10 el0 ctrl");
    op(0, 4'd8, 0, 2'd2, 1, 0, "R10 el2 ctrl");
    // R2 wrap, R12 write precedence
    op(1, 4'd8, 32'h1, 2'd2, 1, 0, "R2 glob on");
    op(1, 4'd0, 32'hFFFF_FFFF, 2'd2, 1, 0, "R2 load max");
    op(0, 4'd0, 0, 2'd2, 1, 6'h01, "R2 pulse old");
    check("R12 read before edge", last_data, 32'hFFFF_FFFF);
    op(0, 4'd0, 0, 2'd2, 1, 0, "R2 wrapped");
    check("R2 wrap zero", last_data, 32'd0);
    op(1, 4'd1, 32'd100, 2'd2, 1, 6'h02, "R12 write+event");
    op(0, 4'd1, 0, 2'd2, 1, 0, "R12 readback");
    check("R12 write wins", last_data, 32'd100);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] a;
      logic [31:0] d;
      string tg;
      a = 4'($urandom_range(0, 11));
      if (a == 4'd6 || a == 4'd7) a = 4'd12;
      d = $urandom;
      if (a == 4'd10) d = {24'd0, d[7], 1'b0, d[5], d[4:0]};
      if (a < 4'd6) tg = "R4 random counter";
      else if (a == 4'd8) tg = "R10 random ctrl";
      else if (a == 4'd9) tg = "R5 random user";
      else if (a == 4'd10) tg = "R9 random hcfg";
      else tg = "R11 random unmapped";
      op(($urandom_range(0, 3) == 0), a, d, 2'($urandom_range(0, 3)),
         1'($urandom_range(0, 1)), 6'($urandom), tg);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule